// File: doc/BRIEF.md
# Double-Buffered Frame Exchange Between Stream Datapath and Firmware

This block sits between a byte-wide frame datapath and a processor-side access port. It has two frame stores, and each store can hold a full frame of up to 2112 bytes. The ingress stream fills the stores in turn. When a frame's final byte arrives, that store passes to firmware. Firmware then has random word access to the whole frame. It can read the frame, patch it or replace it. It hands the store back with a single release strobe. That strobe carries the frame length and a choice: free the store, or queue it for the egress stream.

Because the two stores change hands independently, firmware can work on one complete frame while the datapath streams a different frame into the other store. Each store has a visible owner bit, a stored length and a truncation flag. Firmware accesses to a store that hardware owns are refused and flagged. Frames longer than a store are cut to fit.

Top module: `frame_pingpong_xfer`

## Requirements
- R1: After reset both stores are hardware-owned and free, with stored length 0 and truncation flag 0. `s_ready` is 1 and `m_valid` is 0.
- R2: Ingress byte number i of a frame goes to word i/4 of its store, in bits [8*(i%4)+7 : 8*(i%4)]. The cycle after the byte with `s_last` is accepted, the store is firmware-owned (`buf_fw_own` bit set) and its length equals the byte count N.
- R3: The first frame after reset goes to store 0, and later frames alternate between the stores. `s_ready` is 0 whenever the store next in turn is not free.
- R4: If a frame has more than 2112 bytes, only the first 2112 are stored, the length reads 2112 and the store's `buf_ovf` bit is set. A release clears that bit.
- R5: A firmware read (`fw_en`=1, `fw_we`=0) of a store it owns returns the word on `fw_rdata` with `fw_rvalid`=1 one cycle later, and `fw_err`=0.
- R6: A firmware write to an owned store replaces the addressed 32-bit word, and a later read returns it.
- R7: A firmware read of a store it does not own returns 0, and a write to such a store is ignored. Either access raises `fw_err` for one cycle, one cycle after the access.
- R8: `fw_done` on an owned store sets its length to min(`fw_done_len`, 2112) and clears the owner bit. With `fw_send`=1 and a nonzero length the store is queued for egress; otherwise it becomes free. `fw_done` on a store firmware does not own raises `fw_err` and changes nothing.
- R9: A queued store is streamed out from byte 0 in the R2 layout. Exactly `length` bytes are sent, `m_last` is set on the final byte, and data is held while `m_ready` is low. Once the final byte is taken, the store is free.
- R10: Firmware access to one store goes ahead while the ingress stream fills the other store, with no stall on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Ingress byte valid |
| s_ready | output | 1 | Ingress byte accepted when high with `s_valid` |
| s_data | input | 8 | Ingress byte |
| s_last | input | 1 | Final byte of ingress frame |
| m_valid | output | 1 | Egress byte valid |
| m_ready | input | 1 | Egress byte taken when high with `m_valid` |
| m_data | output | 8 | Egress byte |
| m_last | output | 1 | Final byte of egress frame |
| fw_en | input | 1 | Firmware word access request |
| fw_we | input | 1 | 1 = write, 0 = read |
| fw_buf | input | 1 | Store selected by the access |
| fw_addr | input | 10 | Word address within the store |
| fw_wdata | input | 32 | Write word |
| fw_rvalid | output | 1 | Read data valid (one cycle after a read) |
| fw_rdata | output | 32 | Read word, zero when refused |
| fw_err | output | 1 | Access or release refused (one-cycle pulse) |
| fw_done | input | 1 | Release strobe |
| fw_done_buf | input | 1 | Store being released |
| fw_done_len | input | 12 | Frame length written on release |
| fw_send | input | 1 | 1 = queue for egress on release |
| buf_fw_own | output | 2 | Per-store firmware-owned bit |
| buf_ovf | output | 2 | Per-store truncation flag |
| buf_len | output | 24 | Per-store length, store b in bits [12*b+11:12*b] |

## Verification
The assertions assume that inputs follow the stated handshake rules. Firmware releases only stores that it read from `buf_fw_own`, and `fw_addr` stays within the 528 words of a store. The stream inputs change only at the falling clock edge. The bench drives every input at the falling edge and uses word addresses below 528. It makes its one deliberate refused release on a store it knows is hardware-owned, and it checks that case through `fw_err` and `buf_len`. The egress hold property depends on queued stores not being writable, which the ownership rule ensures, so the bench's irregular `m_ready` pattern stays inside that assumption.

// File: rtl/frame_pp_pkg.sv
package frame_pp_pkg;

  localparam int unsigned NUM_BUFS = 2;

  typedef enum logic [1:0] {
    BS_FREE = 2'd0,
    BS_FW   = 2'd1,
    BS_SEND = 2'd2
  } buf_state_t;

  function automatic int unsigned word_of(input int unsigned idx);
    return idx / 4;
  endfunction

  function automatic int unsigned lane_of(input int unsigned idx);
    return idx % 4;
  endfunction

  function automatic int unsigned clamp_len(input int unsigned n, input int unsigned max_n);
    return (n > max_n) ? max_n : n;
  endfunction

endpackage

// File: rtl/frame_pp_bank.sv
module frame_pp_bank #(
  parameter int unsigned WORDS = 528,
  localparam int unsigned WAW = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [3:0]     wbe,
  input  logic [WAW-1:0] addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < 4; l++) begin
        if (wbe[l]) mem[addr][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/frame_pp_fill.sv
module frame_pp_fill #(
  parameter int unsigned MAX_BYTES = 2112,
  localparam int unsigned LW = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic          s_last,
  input  logic [1:0]    free_mask,
  output logic          s_ready,
  output logic          sel,
  output logic          wr_en,
  output logic [LW-1:0] wr_idx,
  output logic          done_evt,
  output logic [LW-1:0] done_len,
  output logic          done_ovf
);

  logic [LW-1:0] cnt_q;
  logic          trunc_q;
  logic          accept;
  logic          room;

  assign s_ready  = free_mask[sel];
  assign accept   = s_valid && s_ready;
  assign room     = cnt_q < LW'(MAX_BYTES);
  assign wr_en    = accept && room;
  assign wr_idx   = cnt_q;
  assign done_evt = accept && s_last;
  assign done_len = room ? cnt_q + LW'(1) : LW'(MAX_BYTES);
  assign done_ovf = trunc_q || !room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      trunc_q <= 1'b0;
      sel     <= 1'b0;
    end else if (accept) begin
      if (s_last) begin
        cnt_q   <= '0;
        trunc_q <= 1'b0;
        sel     <= ~sel;
      end else if (room) begin
        cnt_q <= cnt_q + LW'(1);
      end else begin
        trunc_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frame_pp_drain.sv
module frame_pp_drain #(
  parameter int unsigned MAX_BYTES = 2112,
  localparam int unsigned LW = $clog2(MAX_BYTES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      send_mask,
  input  logic [2*LW-1:0] lens,
  input  logic            m_ready,
  output logic            m_valid,
  output logic            m_last,
  output logic            sel,
  output logic [LW-1:0]   rd_idx,
  output logic            done_evt
);

  logic          act_q;
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] len_sel;

  assign len_sel  = lens[sel*LW +: LW];
  assign m_valid  = act_q;
  assign m_last   = act_q && (cnt_q == len_sel - LW'(1));
  assign rd_idx   = cnt_q;
  assign done_evt = act_q && m_ready && m_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sel   <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (|send_mask) begin
        act_q <= 1'b1;
        sel   <= !send_mask[0];
        cnt_q <= '0;
      end
    end else if (m_ready) begin
      if (m_last) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + LW'(1);
      end
    end
  end

endmodule

// File: rtl/frame_pingpong_xfer.sv
module frame_pingpong_xfer
  import frame_pp_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 2112,
  localparam int unsigned LW    = $clog2(MAX_BYTES + 1),
  localparam int unsigned WORDS = (MAX_BYTES + 3) / 4,
  localparam int unsigned WAW   = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [7:0]      s_data,
  input  logic            s_last,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [7:0]      m_data,
  output logic            m_last,
  input  logic            fw_en,
  input  logic            fw_we,
  input  logic            fw_buf,
  input  logic [WAW-1:0]  fw_addr,
  input  logic [31:0]     fw_wdata,
  output logic            fw_rvalid,
  output logic [31:0]     fw_rdata,
  output logic            fw_err,
  input  logic            fw_done,
  input  logic            fw_done_buf,
  input  logic [LW-1:0]   fw_done_len,
  input  logic            fw_send,
  output logic [1:0]      buf_fw_own,
  output logic [1:0]      buf_ovf,
  output logic [2*LW-1:0] buf_len
);

  // Named internal events, also used by the bound checker
  logic          fill_sel_w, drain_sel_w, fill_evt_w, drain_evt_w;
  logic          fill_wr_w, fill_ovf_w;
  logic [LW-1:0] fill_idx_w, fill_len_w, drain_idx_w;
  logic          fw_bad_w, done_ok_w;
  logic [LW-1:0] done_len_c;

  logic [1:0]       free_mask, send_mask, own_mask;
  logic [1:0][31:0] rd_all;
  logic [WAW-1:0]   fill_word, drain_word;
  logic [3:0]       fill_be;
  logic [1:0]       drain_lane;

  frame_pp_fill #(.MAX_BYTES(MAX_BYTES)) fill_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_last(s_last),
    .free_mask(free_mask), .s_ready(s_ready), .sel(fill_sel_w),
    .wr_en(fill_wr_w), .wr_idx(fill_idx_w), .done_evt(fill_evt_w),
    .done_len(fill_len_w), .done_ovf(fill_ovf_w)
  );

  frame_pp_drain #(.MAX_BYTES(MAX_BYTES)) drain_i (
    .clk(clk), .rst_n(rst_n), .send_mask(send_mask), .lens(buf_len),
    .m_ready(m_ready), .m_valid(m_valid), .m_last(m_last),
    .sel(drain_sel_w), .rd_idx(drain_idx_w), .done_evt(drain_evt_w)
  );

  assign fill_word  = WAW'(word_of(32'(fill_idx_w)));
  assign fill_be    = 4'b0001 << 2'(lane_of(32'(fill_idx_w)));
  assign drain_word = WAW'(word_of(32'(drain_idx_w)));
  assign drain_lane = 2'(lane_of(32'(drain_idx_w)));
  assign m_data     = rd_all[drain_sel_w][{drain_lane, 3'b000} +: 8];

  assign fw_bad_w   = (fw_en && !own_mask[fw_buf]) || (fw_done && !own_mask[fw_done_buf]);
  assign done_ok_w  = fw_done && own_mask[fw_done_buf];
  assign done_len_c = LW'(clamp_len(32'(fw_done_len), MAX_BYTES));
  assign buf_fw_own = own_mask;

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    buf_state_t     st_q;
    logic [LW-1:0]  len_q;
    logic           ovf_q;
    logic           we;
    logic [3:0]     be;
    logic [WAW-1:0] addr;
    logic [31:0]    wd;

    assign own_mask[b]        = (st_q == BS_FW);
    assign free_mask[b]       = (st_q == BS_FREE);
    assign send_mask[b]       = (st_q == BS_SEND);
    assign buf_len[b*LW +: LW] = len_q;
    assign buf_ovf[b]         = ovf_q;

    // Single port: firmware while it owns the store, the streams otherwise
    always_comb begin
      we   = 1'b0;
      be   = 4'h0;
      wd   = '0;
      addr = drain_word;
      if (st_q == BS_FW) begin
        addr = fw_addr;
        if (fw_en && fw_we && (fw_buf == 1'(b))) begin
          we = 1'b1;
          be = 4'hF;
          wd = fw_wdata;
        end
      end else if (fill_wr_w && (fill_sel_w == 1'(b))) begin
        we   = 1'b1;
        be   = fill_be;
        addr = fill_word;
        wd   = {4{s_data}};
      end
    end

    frame_pp_bank #(.WORDS(WORDS)) bank_i (
      .clk(clk), .we(we), .wbe(be), .addr(addr), .wdata(wd), .rdata(rd_all[b])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q  <= BS_FREE;
        len_q <= '0;
        ovf_q <= 1'b0;
      end else if (fill_evt_w && (fill_sel_w == 1'(b))) begin
        st_q  <= BS_FW;
        len_q <= fill_len_w;
        ovf_q <= fill_ovf_w;
      end else if (done_ok_w && (fw_done_buf == 1'(b))) begin
        len_q <= done_len_c;
        ovf_q <= 1'b0;
        st_q  <= (fw_send && (done_len_c != '0)) ? BS_SEND : BS_FREE;
      end else if (drain_evt_w && (drain_sel_w == 1'(b))) begin
        st_q <= BS_FREE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fw_rvalid <= 1'b0;
      fw_rdata  <= '0;
      fw_err    <= 1'b0;
    end else begin
      fw_rvalid <= fw_en && !fw_we;
      fw_err    <= fw_bad_w;
      if (fw_en && !fw_we) fw_rdata <= own_mask[fw_buf] ? rd_all[fw_buf] : '0;
    end
  end

endmodule

// File: rtl/frame_pp_checker.sv
module frame_pp_checker #(
  parameter int unsigned MAX_BYTES = 2112,
  localparam int unsigned LW = $clog2(MAX_BYTES + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            s_ready,
  input logic            m_valid,
  input logic            m_ready,
  input logic [7:0]      m_data,
  input logic            m_last,
  input logic            fw_en,
  input logic            fw_done,
  input logic            fw_rvalid,
  input logic [31:0]     fw_rdata,
  input logic            fw_err,
  input logic [1:0]      buf_fw_own,
  input logic [1:0]      buf_ovf,
  input logic [2*LW-1:0] buf_len,
  input logic            fill_sel_w,
  input logic            drain_sel_w,
  input logic            fill_evt_w,
  input logic            drain_evt_w
);

  AST_HANDOFF_TO_FW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt_w |=> buf_fw_own[$past(fill_sel_w)]); // R2
  AST_READY_TARGET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !buf_fw_own[fill_sel_w]); // R3
  AST_FILL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt_w |=> (fill_sel_w != $past(fill_sel_w))); // R3
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_len[LW-1:0] <= LW'(MAX_BYTES)) && (buf_len[2*LW-1:LW] <= LW'(MAX_BYTES))); // R4
  AST_OVF_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ovf[0] |-> buf_len[LW-1:0] == LW'(MAX_BYTES)) and
    (buf_ovf[1] |-> buf_len[2*LW-1:LW] == LW'(MAX_BYTES))); // R4
  AST_REFUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_rvalid && fw_err) |-> (fw_rdata == 32'h0)); // R7
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fw_err |-> $past(fw_en || fw_done)); // R7
  AST_EGRESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last))); // R9
  AST_EGRESS_NOT_FW: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !buf_fw_own[drain_sel_w]); // R9
  AST_DRAIN_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt_w |=> (!m_valid && !buf_fw_own[$past(drain_sel_w)])); // R9

endmodule

bind frame_pingpong_xfer frame_pp_checker #(.MAX_BYTES(MAX_BYTES)) chk_i (.*);

// File: tb/frame_pingpong_xfer_tb.sv
module frame_pingpong_xfer_tb_top;
  localparam int MAXB = 2112;
  localparam int LW = 12;
  localparam int WAW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 0, s_last = 0, m_ready = 0;
  logic [7:0] s_data = 0;
  logic s_ready, m_valid, m_last;
  logic [7:0] m_data;
  logic fw_en = 0, fw_we = 0, fw_buf = 0, fw_done = 0, fw_done_buf = 0, fw_send = 0;
  logic [WAW-1:0] fw_addr = 0;
  logic [31:0] fw_wdata = 0;
  logic [LW-1:0] fw_done_len = 0;
  logic fw_rvalid, fw_err;
  logic [31:0] fw_rdata;
  logic [1:0] buf_fw_own, buf_ovf;
  logic [2*LW-1:0] buf_len;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  frame_pingpong_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .fw_en(fw_en), .fw_we(fw_we), .fw_buf(fw_buf), .fw_addr(fw_addr), .fw_wdata(fw_wdata),
    .fw_rvalid(fw_rvalid), .fw_rdata(fw_rdata), .fw_err(fw_err), .fw_done(fw_done),
    .fw_done_buf(fw_done_buf), .fw_done_len(fw_done_len), .fw_send(fw_send),
    .buf_fw_own(buf_fw_own), .buf_ovf(buf_ovf), .buf_len(buf_len)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed + i * 3 + (i >> 8));
  endfunction

  function automatic logic [31:0] pat_word(input int seed, input int w);
    return {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input bit last);
    s_valid = 1'b1; s_data = d; s_last = last;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send_frame(input int seed, input int n);
    for (int i = 0; i < n; i++) push_byte(pat(seed, i), i == n - 1);
  endtask

  task automatic fw_read(input logic b, input int w, output logic [31:0] d, output logic e, output logic v);
    fw_en = 1'b1; fw_we = 1'b0; fw_buf = b; fw_addr = WAW'(w);
    @(negedge clk);
    fw_en = 1'b0;
    d = fw_rdata; e = fw_err; v = fw_rvalid;
  endtask

  task automatic fw_write(input logic b, input int w, input logic [31:0] d, output logic e);
    fw_en = 1'b1; fw_we = 1'b1; fw_buf = b; fw_addr = WAW'(w); fw_wdata = d;
    @(negedge clk);
    fw_en = 1'b0; fw_we = 1'b0;
    e = fw_err;
  endtask

  task automatic fw_release(input logic b, input int len, input logic send, output logic e);
    fw_done = 1'b1; fw_done_buf = b; fw_done_len = LW'(len); fw_send = send;
    @(negedge clk);
    fw_done = 1'b0; fw_send = 1'b0;
    e = fw_err;
  endtask

  // R1
  task automatic t_reset;
    chk(s_ready === 1'b1 && m_valid === 1'b0, "R1 ready/valid", {s_ready, m_valid}, 2'b10);
    chk(buf_fw_own === 2'b00 && buf_ovf === 2'b00, "R1 own/ovf", {buf_fw_own, buf_ovf}, 0);
    chk(buf_len === '0, "R1 len", 32'(buf_len), 0);
  endtask

  // R2 R3 R5: first frame lands in store 0
  task automatic t_first_frame;
    logic [31:0] d; logic e, v;
    send_frame(8'h10, 10);
    chk(buf_fw_own === 2'b01, "R3 store0 first", buf_fw_own, 2'b01);
    chk(buf_len[LW-1:0] === 12'd10 && buf_ovf === 2'b00, "R2 len", buf_len[LW-1:0], 10);
    for (int w = 0; w < 2; w++) begin
      fw_read(1'b0, w, d, e, v);
      chk(v === 1'b1 && e === 1'b0, "R5 rvalid/err", {v, e}, 2'b10);
      chk(d === pat_word(8'h10, w), "R2 byte layout", d, pat_word(8'h10, w));
    end
  endtask

  // R10: firmware reads store 0 while store 1 fills
  task automatic t_overlap;
    logic [31:0] d0, d1; logic e0, e1, v0, v1;
    int t0, t1;
    t0 = $time;
    fork
      send_frame(8'h40, 6);
      begin
        fw_read(1'b0, 0, d0, e0, v0);
        fw_read(1'b0, 1, d1, e1, v1);
      end
    join
    t1 = $time;
    chk(d0 === pat_word(8'h10, 0) && d1 === pat_word(8'h10, 1) && !e0 && !e1,
        "R10 fw read during fill", d1, pat_word(8'h10, 1));
    chk((t1 - t0) == 60, "R10 no stall", t1 - t0, 60);
    chk(buf_fw_own === 2'b11 && buf_len[2*LW-1:LW] === 12'd6, "R2 store1 len", buf_len, 0);
  endtask

  // R3 R7 R8 R6 R9
  task automatic t_stall_refuse_send;
    logic [31:0] d; logic e, v;
    logic [7:0] exp_b [8];
    int got, k;
    chk(s_ready === 1'b0, "R3 stall when next store fw-owned", s_ready, 0);
    fw_release(1'b0, 0, 1'b0, e);
    chk(s_ready === 1'b1 && buf_fw_own === 2'b10 && !e, "R8 release frees", {s_ready, buf_fw_own}, 3'b110);
    fw_read(1'b0, 0, d, e, v);
    chk(d === 32'h0 && e === 1'b1 && v === 1'b1, "R7 refused read", {d[7:0], e}, 9'h001);
    fw_write(1'b0, 0, 32'hDEADBEEF, e);
    chk(e === 1'b1, "R7 refused write flag", e, 1);
    @(negedge clk);
    chk(fw_err === 1'b0, "R7 err is one cycle", fw_err, 0);
    send_frame(8'h55, 1);
    chk(buf_fw_own === 2'b11 && buf_len[LW-1:0] === 12'd1, "R3 alternation back to store0", buf_fw_own, 2'b11);
    fw_read(1'b0, 0, d, e, v);
    chk(d === {pat(8'h10, 3), pat(8'h10, 2), pat(8'h10, 1), 8'h55}, "R7 write ignored", d,
        {pat(8'h10, 3), pat(8'h10, 2), pat(8'h10, 1), 8'h55});
    fw_write(1'b0, 1, 32'h11223344, e);
    fw_read(1'b0, 1, d, e, v);
    chk(d === 32'h11223344 && !e, "R6 write then read", d, 32'h11223344);
    exp_b = '{8'h55, pat(8'h10, 1), pat(8'h10, 2), pat(8'h10, 3), 8'h44, 8'h33, 8'h22, 8'h11};
    fw_release(1'b0, 8, 1'b1, e);
    got = 0; k = 0;
    while (got < 8 && k < 200) begin
      m_ready = (k % 3) != 1;
      if (m_valid && m_ready) begin
        chk(m_data === exp_b[got], "R9 egress byte", m_data, exp_b[got]);
        chk(m_last === (got == 7), "R9 last flag", m_last, got == 7);
        got++;
      end
      k++;
      @(negedge clk);
    end
    m_ready = 1'b0;
    chk(got == 8, "R9 byte count", got, 8);
    chk(m_valid === 1'b0 && buf_fw_own === 2'b10, "R9 store freed", {m_valid, buf_fw_own}, 3'b010);
  endtask

  // R8 clamp and refused release; R4 truncation
  task automatic t_clamp_overflow;
    logic [31:0] d; logic e, v;
    fw_release(1'b1, 4000, 1'b0, e);
    chk(buf_len[2*LW-1:LW] === 12'd2112 && buf_fw_own === 2'b00, "R8 clamp", buf_len[2*LW-1:LW], 2112);
    fw_release(1'b1, 5, 1'b0, e);
    chk(e === 1'b1 && buf_len[2*LW-1:LW] === 12'd2112, "R8 refused release", {e, buf_len[2*LW-1:LW]}, 13'h1840);
    send_frame(8'h21, MAXB + 5);
    chk(buf_len[2*LW-1:LW] === 12'd2112 && buf_ovf === 2'b10 && buf_fw_own === 2'b10,
        "R4 truncated frame", {buf_ovf, buf_len[2*LW-1:LW]}, {2'b10, 12'd2112});
    fw_read(1'b1, MAXB / 4 - 1, d, e, v);
    chk(d === pat_word(8'h21, MAXB / 4 - 1), "R4 last stored word", d, pat_word(8'h21, MAXB / 4 - 1));
    fw_release(1'b1, 0, 1'b0, e);
    chk(buf_ovf === 2'b00, "R4 ovf cleared on release", buf_ovf, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_frame();
    t_overlap();
    t_stall_refuse_send();
    t_clamp_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule